// File: doc/BRIEF.md
# Control-Structure Pointer Store Unit

This block executes the "store current control-structure pointer" operation of a processor that supports hardware virtualization. It takes one request at a time over a valid/ready handshake. Each request carries the decoded operand form, the processor mode bits, the privilege level, the attributes and limit of the segment that holds the destination, and the effective address. The block then settles on exactly one outcome.

The checks run in a fixed order. Undefined-opcode conditions come first, then the exit to the monitor for guest (non-root) code, then privilege, then the segment and address-form faults. Only a request that passes all of them causes a memory access. In that case the unit issues one 64-bit write of its held pointer to the effective address. A page fault that the memory side reports for that write turns into a page-fault outcome. The outcome is a one-hot code with an error code, and success also asks the flag logic to clear the arithmetic status flags. A neighbouring load operation updates the held pointer through a load strobe.

Top module: `vptr_store_unit`

## Requirements
- R1: Each accepted request yields exactly one result pulse: `res_valid` is high for one cycle and `res_kind` is one-hot. The bits are 0 invalid-opcode, 1 monitor exit, 2 general-protection, 3 stack-fault and 4 page-fault, and bit 5 means success. `res_kind` is zero when `res_valid` is low.
- R2: Invalid-opcode is reported ahead of every other outcome when any of these holds: the operand is a register, virtualization is off, protection enable is 0, the virtual-8086 flag is 1, or long mode is active while the code-segment long bit is 0.
- R3: With no invalid-opcode condition, a non-root request yields a monitor exit, whatever its privilege or address.
- R4: In root operation, a privilege level other than 0 yields general-protection with error code 0, ahead of any segment or address fault.
- R5: Outside 64-bit mode the offset is `req_addr[31:0]`, and the access spans offset to offset+7, summed in 33 bits. For a segment other than SS the result is general-protection(0) in three cases: the segment is unusable, the segment is code or not writable, or offset+7 exceeds the limit. Segment codes: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS.
- R6: Outside 64-bit mode with SS (code 2) selected, three checks apply in this order. An unusable SS gives stack-fault(0). A code or non-writable SS gives general-protection(0). Offset+7 above the limit gives stack-fault(0).
- R7: In 64-bit mode (long mode active and code-segment long bit 1), an address is canonical when bits 63 down to 47 are all equal. A non-canonical address gives stack-fault(0) if SS is selected and general-protection(0) otherwise. Limit, usability and segment type are not checked in this mode.
- R8: A request that passes all checks causes one write of the held 64-bit pointer to `req_addr`. Address and data hold steady while the write waits for `mem_wr_ready`, and `req_ready` stays low until the write is accepted.
- R9: If `mem_pf` is high when the write is accepted, the result is page-fault and `res_err_code` equals `mem_pf_code`.
- R10: A write accepted without a page fault gives success together with a one-cycle `res_flag_clear` pulse. Faults and exits issue no write and no flag clear.
- R11: A faulting or exiting request reports its result in the cycle after it is accepted. A write reports its result in the cycle after `mem_wr_ready` accepts it.
- R12: The held pointer is all ones after reset, meaning no current structure. `ptr_load` replaces it with `ptr_load_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_is_reg | input | 1 | Operand decoded as a register |
| req_virt_on | input | 1 | Virtualization operation enabled |
| req_non_root | input | 1 | Running as guest (non-root) |
| req_prot_en | input | 1 | Protection enable |
| req_v86 | input | 1 | Virtual-8086 flag |
| req_long_act | input | 1 | Long mode active |
| req_cs_long | input | 1 | Code-segment long bit |
| req_cpl | input | 2 | Current privilege level |
| req_seg | input | 3 | Destination segment code |
| req_seg_usable | input | 1 | Segment usable |
| req_seg_code | input | 1 | Segment is a code segment |
| req_seg_writable | input | 1 | Data segment writable |
| req_seg_limit | input | 32 | Segment limit (last valid byte offset) |
| req_addr | input | 64 | Effective address |
| ptr_load | input | 1 | Replace held pointer |
| ptr_load_val | input | 64 | New pointer value |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | 64 | Write address |
| mem_wr_data | output | 64 | Write data (held pointer) |
| mem_pf | input | 1 | Page fault on the accepted write |
| mem_pf_code | input | 32 | Page-fault error code |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 6 | One-hot outcome |
| res_err_code | output | 32 | Error code for the outcome |
| res_flag_clear | output | 1 | Clear arithmetic status flags |

## Verification
A wrong internal state shows up at the ports on the cycle after the request that exposes it. A stuck sequencer keeps `req_ready` low or never pulses `res_valid`. A mis-ordered check chain produces the wrong one-hot bit on the very next cycle. A corrupted or unreset pointer appears as wrong `mem_wr_data` on the first successful store. A write that releases too early shows as a result that arrives one cycle off, or as address and data changing while `mem_wr_ready` is low.

// File: rtl/vps_pkg.sv
package vps_pkg;

    localparam int ADDR_W     = 64;
    localparam int PTR_W      = 64;
    localparam int LIMIT_W    = 32;
    localparam int ERR_W      = 32;
    localparam int LIN_BITS   = 48;
    localparam int OPND_BYTES = 8;
    localparam int CPL_W      = 2;

    localparam int NUM_RES = 6;
    localparam int RB_UD   = 0;
    localparam int RB_EXIT = 1;
    localparam int RB_GP   = 2;
    localparam int RB_SS   = 3;
    localparam int RB_PF   = 4;
    localparam int RB_OK   = 5;

    typedef logic [NUM_RES-1:0] res_kind_t;

    typedef enum logic [2:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    typedef struct packed {
        logic              is_reg;
        logic              virt_on;
        logic              non_root;
        logic              prot_en;
        logic              v86;
        logic              long_act;
        logic              cs_long;
        logic [CPL_W-1:0]  cpl;
        seg_e              seg;
        logic              usable;
        logic              is_code;
        logic              writable;
        logic [LIMIT_W-1:0] limit;
        logic [ADDR_W-1:0] addr;
    } req_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } seq_state_e;

    function automatic res_kind_t kind_bit(input int idx);
        res_kind_t k;
        k = '0;
        k[idx] = 1'b1;
        return k;
    endfunction

    function automatic logic addr_canonical(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-LIN_BITS:0] top;
        top = a[ADDR_W-1:LIN_BITS-1];
        return (&top) | ~(|top);
    endfunction

endpackage

// File: rtl/vps_fault_eval.sv
module vps_fault_eval
    import vps_pkg::*;
(
    input  req_t      req,
    output logic      fault,
    output res_kind_t kind
);

    localparam logic [LIMIT_W:0] SPAN = (LIMIT_W+1)'(OPND_BYTES - 1);

    logic             mode64;
    logic             ud_hit;
    logic             is_ss;
    logic             canon;
    logic [LIMIT_W:0] last_off;
    logic             past_limit;
    logic             no_write;

    always_comb begin
        mode64     = req.long_act & req.cs_long;
        ud_hit     = req.is_reg | ~req.virt_on | ~req.prot_en | req.v86 |
                     (req.long_act & ~req.cs_long);
        is_ss      = (req.seg == SEG_SS);
        canon      = addr_canonical(req.addr);
        last_off   = {1'b0, req.addr[LIMIT_W-1:0]} + SPAN;
        past_limit = last_off > {1'b0, req.limit};
        no_write   = req.is_code | ~req.writable;
    end

    always_comb begin
        fault = 1'b1;
        kind  = '0;
        if (ud_hit) begin
            kind = kind_bit(RB_UD);
        end else if (req.non_root) begin
            kind = kind_bit(RB_EXIT);
        end else if (req.cpl != '0) begin
            kind = kind_bit(RB_GP);
        end else if (mode64) begin
            if (!canon) begin
                kind = is_ss ? kind_bit(RB_SS) : kind_bit(RB_GP);
            end else begin
                fault = 1'b0;
            end
        end else if (!req.usable) begin
            kind = is_ss ? kind_bit(RB_SS) : kind_bit(RB_GP);
        end else if (no_write) begin
            kind = kind_bit(RB_GP);
        end else if (past_limit) begin
            kind = is_ss ? kind_bit(RB_SS) : kind_bit(RB_GP);
        end else begin
            fault = 1'b0;
        end
    end

endmodule

// File: rtl/vps_ptr_reg.sv
module vps_ptr_reg
    import vps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '1;
        end else if (load) begin
            ptr <= load_val;
        end
    end

endmodule

// File: rtl/vps_seq.sv
module vps_seq
    import vps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              eval_fault,
    input  res_kind_t         eval_kind,
    input  logic [PTR_W-1:0]  ptr,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [PTR_W-1:0]  mem_wr_data,
    input  logic              mem_pf,
    input  logic [ERR_W-1:0]  mem_pf_code,
    output logic              res_valid,
    output res_kind_t         res_kind,
    output logic [ERR_W-1:0]  res_err_code,
    output logic              res_flag_clear
);

    seq_state_e state_q;

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_wr_valid = (state_q == ST_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            res_valid      <= 1'b0;
            res_kind       <= '0;
            res_err_code   <= '0;
            res_flag_clear <= 1'b0;
            mem_wr_addr    <= '0;
            mem_wr_data    <= '0;
        end else begin
            res_valid      <= 1'b0;
            res_kind       <= '0;
            res_err_code   <= '0;
            res_flag_clear <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (eval_fault) begin
                            res_valid <= 1'b1;
                            res_kind  <= eval_kind;
                        end else begin
                            state_q     <= ST_WRITE;
                            mem_wr_addr <= req_addr;
                            mem_wr_data <= ptr;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ready) begin
                        state_q   <= ST_IDLE;
                        res_valid <= 1'b1;
                        if (mem_pf) begin
                            res_kind     <= kind_bit(RB_PF);
                            res_err_code <= mem_pf_code;
                        end else begin
                            res_kind       <= kind_bit(RB_OK);
                            res_flag_clear <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vptr_store_unit.sv
module vptr_store_unit
    import vps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_is_reg,
    input  logic                req_virt_on,
    input  logic                req_non_root,
    input  logic                req_prot_en,
    input  logic                req_v86,
    input  logic                req_long_act,
    input  logic                req_cs_long,
    input  logic [1:0]          req_cpl,
    input  logic [2:0]          req_seg,
    input  logic                req_seg_usable,
    input  logic                req_seg_code,
    input  logic                req_seg_writable,
    input  logic [31:0]         req_seg_limit,
    input  logic [63:0]         req_addr,
    input  logic                ptr_load,
    input  logic [63:0]         ptr_load_val,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [63:0]         mem_wr_addr,
    output logic [63:0]         mem_wr_data,
    input  logic                mem_pf,
    input  logic [31:0]         mem_pf_code,
    output logic                res_valid,
    output logic [5:0]          res_kind,
    output logic [31:0]         res_err_code,
    output logic                res_flag_clear
);

    req_t             req_s;
    logic             eval_fault;
    res_kind_t        eval_kind;
    logic [PTR_W-1:0] ptr_q;

    always_comb begin
        req_s.is_reg   = req_is_reg;
        req_s.virt_on  = req_virt_on;
        req_s.non_root = req_non_root;
        req_s.prot_en  = req_prot_en;
        req_s.v86      = req_v86;
        req_s.long_act = req_long_act;
        req_s.cs_long  = req_cs_long;
        req_s.cpl      = req_cpl;
        req_s.seg      = seg_e'(req_seg);
        req_s.usable   = req_seg_usable;
        req_s.is_code  = req_seg_code;
        req_s.writable = req_seg_writable;
        req_s.limit    = req_seg_limit;
        req_s.addr     = req_addr;
    end

    vps_fault_eval u_eval (
        .req   (req_s),
        .fault (eval_fault),
        .kind  (eval_kind)
    );

    vps_ptr_reg u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .ptr      (ptr_q)
    );

    vps_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .eval_fault     (eval_fault),
        .eval_kind      (eval_kind),
        .ptr            (ptr_q),
        .mem_wr_valid   (mem_wr_valid),
        .mem_wr_ready   (mem_wr_ready),
        .mem_wr_addr    (mem_wr_addr),
        .mem_wr_data    (mem_wr_data),
        .mem_pf         (mem_pf),
        .mem_pf_code    (mem_pf_code),
        .res_valid      (res_valid),
        .res_kind       (res_kind),
        .res_err_code   (res_err_code),
        .res_flag_clear (res_flag_clear)
    );

endmodule

// File: rtl/vps_checker.sv
module vps_checker
    import vps_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_is_reg,
    input logic        req_virt_on,
    input logic        req_non_root,
    input logic        req_prot_en,
    input logic        req_v86,
    input logic        req_long_act,
    input logic        req_cs_long,
    input logic [1:0]  req_cpl,
    input logic        mem_wr_valid,
    input logic        mem_wr_ready,
    input logic [63:0] mem_wr_addr,
    input logic [63:0] mem_wr_data,
    input logic        mem_pf,
    input logic        res_valid,
    input logic [5:0]  res_kind,
    input logic [31:0] res_err_code,
    input logic        res_flag_clear
);

    logic accept;
    logic no_ud;
    assign accept = req_valid & req_ready;
    assign no_ud  = ~req_is_reg & req_virt_on & req_prot_en & ~req_v86 &
                    ~(req_long_act & ~req_cs_long);

    assert_result_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $countones(res_kind) == 1);

    assert_kind_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> res_kind == '0);

    assert_regform_ud_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && req_is_reg) |=> (res_valid && res_kind == kind_bit(RB_UD)));

    assert_nonroot_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && no_ud && req_non_root) |=> (res_valid && res_kind == kind_bit(RB_EXIT)));

    assert_cpl_gp_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && no_ud && !req_non_root && req_cpl != 2'd0) |=>
        (res_valid && res_kind == kind_bit(RB_GP) && res_err_code == '0));

    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
        (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> !req_ready);

    assert_pf_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind[RB_PF]) |-> $past(mem_wr_valid && mem_wr_ready && mem_pf));

    assert_ok_after_write_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind[RB_OK]) |->
        ($past(mem_wr_valid && mem_wr_ready && !mem_pf) && res_flag_clear));

    assert_flag_only_ok_R10: assert property (@(posedge clk) disable iff (rst)
        res_flag_clear |-> (res_valid && res_kind[RB_OK]));

endmodule

bind vptr_store_unit vps_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_is_reg     (req_is_reg),
    .req_virt_on    (req_virt_on),
    .req_non_root   (req_non_root),
    .req_prot_en    (req_prot_en),
    .req_v86        (req_v86),
    .req_long_act   (req_long_act),
    .req_cs_long    (req_cs_long),
    .req_cpl        (req_cpl),
    .mem_wr_valid   (mem_wr_valid),
    .mem_wr_ready   (mem_wr_ready),
    .mem_wr_addr    (mem_wr_addr),
    .mem_wr_data    (mem_wr_data),
    .mem_pf         (mem_pf),
    .res_valid      (res_valid),
    .res_kind       (res_kind),
    .res_err_code   (res_err_code),
    .res_flag_clear (res_flag_clear)
);

// File: tb/vptr_store_unit_test.sv
`timescale 1ns/1ps
module vptr_store_unit_test;

    localparam logic [5:0] K_UD = 6'b000001;
    localparam logic [5:0] K_EX = 6'b000010;
    localparam logic [5:0] K_GP = 6'b000100;
    localparam logic [5:0] K_SS = 6'b001000;
    localparam logic [5:0] K_PF = 6'b010000;
    localparam logic [5:0] K_OK = 6'b100000;
    localparam logic [63:0] PTR_A = 64'h0123_4567_89AB_CDE0;

    typedef struct packed {
        logic        is_reg;
        logic        virt;
        logic        nonroot;
        logic        pe;
        logic        v86;
        logic        lma;
        logic        csl;
        logic [1:0]  cpl;
        logic [2:0]  seg;
        logic        usable;
        logic        code;
        logic        wr;
        logic [31:0] limit;
        logic [63:0] addr;
        logic        pf;
        logic [31:0] pfcode;
        logic [5:0]  kind;
        logic [31:0] ecode;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1,1,1,1,0,0,0,2'd3,3'd3,1,0,1,32'hFFF,64'hFF8,0,32'h0,K_UD,32'h0},
        '{0,0,1,1,0,0,0,2'd3,3'd3,1,0,1,32'hFFF,64'hFF8,0,32'h0,K_UD,32'h0},
        '{0,1,1,0,0,0,0,2'd3,3'd3,1,0,1,32'hFFF,64'hFF8,0,32'h0,K_UD,32'h0},
        '{0,1,0,1,1,0,0,2'd0,3'd3,1,0,1,32'hFFF,64'hFF8,0,32'h0,K_UD,32'h0},
        '{0,1,0,1,0,1,0,2'd0,3'd3,1,0,1,32'hFFF,64'hFF8,0,32'h0,K_UD,32'h0},
        '{0,1,1,1,0,0,0,2'd3,3'd3,0,0,1,32'hFFF,64'hFF8,0,32'h0,K_EX,32'h0},
        '{0,1,0,1,0,0,0,2'd3,3'd3,0,0,1,32'hFFF,64'hFF8,0,32'h0,K_GP,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd3,0,0,1,32'hFFF,64'hFF8,0,32'h0,K_GP,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd2,0,0,1,32'hFFF,64'hFF8,0,32'h0,K_SS,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd3,1,1,0,32'hFFF,64'hFF8,0,32'h0,K_GP,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd3,1,0,0,32'hFFF,64'hFF8,0,32'h0,K_GP,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd2,1,0,0,32'hFFF,64'hFF9,0,32'h0,K_GP,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd3,1,0,1,32'hFFF,64'hFF9,0,32'h0,K_GP,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd2,1,0,1,32'hFFF,64'hFF9,0,32'h0,K_SS,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd3,1,0,1,32'hFFF,64'hFF8,0,32'h0,K_OK,32'h0},
        '{0,1,0,1,0,0,0,2'd0,3'd3,1,0,1,32'hFFFF_FFFF,64'hFFFF_FFFC,0,32'h0,K_GP,32'h0},
        '{0,1,0,1,0,1,1,2'd0,3'd3,1,0,1,32'hFFF,64'h0000_8000_0000_0000,0,32'h0,K_GP,32'h0},
        '{0,1,0,1,0,1,1,2'd0,3'd2,1,0,1,32'hFFF,64'h0000_8000_0000_0000,0,32'h0,K_SS,32'h0},
        '{0,1,0,1,0,1,1,2'd0,3'd3,0,1,0,32'h0,64'hFFFF_8000_0000_0010,0,32'h0,K_OK,32'h0},
        '{0,1,0,1,0,1,1,2'd0,3'd3,1,0,1,32'h0,64'h0000_7FFF_FFFF_FFF8,1,32'h7,K_PF,32'h7},
        '{0,1,0,1,0,0,0,2'd0,3'd4,1,0,1,32'h1FF,64'hDEAD_0000_0000_0100,0,32'h0,K_OK,32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    vec_t        cur = '0;
    logic        ptr_load = 1'b0;
    logic [63:0] ptr_load_val = '0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [63:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        res_valid;
    logic [5:0]  res_kind;
    logic [31:0] res_err_code;
    logic        res_flag_clear;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    logic [63:0] cap_addr = '0;
    logic [63:0] cap_data = '0;
    logic        busy_seen = 1'b0;

    always #4 clk = ~clk;

    vptr_store_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_reg(cur.is_reg), .req_virt_on(cur.virt), .req_non_root(cur.nonroot),
        .req_prot_en(cur.pe), .req_v86(cur.v86), .req_long_act(cur.lma),
        .req_cs_long(cur.csl), .req_cpl(cur.cpl), .req_seg(cur.seg),
        .req_seg_usable(cur.usable), .req_seg_code(cur.code),
        .req_seg_writable(cur.wr), .req_seg_limit(cur.limit), .req_addr(cur.addr),
        .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_pf(cur.pf), .mem_pf_code(cur.pfcode),
        .res_valid(res_valid), .res_kind(res_kind), .res_err_code(res_err_code),
        .res_flag_clear(res_flag_clear)
    );

    // memory model: accepts a write one cycle after it appears
    always @(negedge clk) begin
        if (mem_wr_valid && !mem_wr_ready) begin
            mem_wr_ready = 1'b1;
            cap_addr = mem_wr_addr;
            cap_data = mem_wr_data;
            busy_seen = !req_ready;
            wr_count++;
        end else begin
            mem_wr_ready = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] k);
        case (k)
            K_UD:    return "R2 invalid-opcode";
            K_EX:    return "R3 monitor exit";
            K_GP:    return "R4 R5 R6 R7 general-protection";
            K_SS:    return "R6 R7 stack-fault";
            K_PF:    return "R9 page-fault";
            default: return "R8 R10 success";
        endcase
    endfunction

    task automatic run_req(input vec_t v, input logic [63:0] exp_data);
        int n;
        int wr0;
        wr0 = wr_count;
        @(negedge clk);
        cur = v;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!res_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        check({tag_of(v.kind), " kind"}, 64'(res_kind), 64'(v.kind));
        check({tag_of(v.kind), " err code"}, 64'(res_err_code), 64'(v.ecode));
        check("R10 flag clear", 64'(res_flag_clear), 64'(v.kind == K_OK));
        check("R11 latency", 64'(n), (v.kind == K_OK || v.kind == K_PF) ? 64'd2 : 64'd1);
        if (v.kind == K_OK || v.kind == K_PF) begin
            check("R8 write count", 64'(wr_count - wr0), 64'd1);
            check("R8 write addr", cap_addr, v.addr);
            check("R8 write data", cap_data, exp_data);
            check("R8 ready low while writing", 64'(busy_seen), 64'd1);
        end else begin
            check("R10 no write on fault", 64'(wr_count - wr0), 64'd0);
        end
        @(negedge clk);
        check("R1 single pulse", 64'(res_valid), 64'd0);
        check("R1 kind quiet", 64'(res_kind), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset res_valid", 64'(res_valid), 64'd0);
        check("R8 reset req_ready", 64'(req_ready), 64'd1);
        check("R8 reset mem_wr_valid", 64'(mem_wr_valid), 64'd0);

        // R12: pointer after reset is all ones
        run_req(VEC[14], 64'hFFFF_FFFF_FFFF_FFFF);

        @(negedge clk);
        ptr_load = 1'b1;
        ptr_load_val = PTR_A;
        @(negedge clk);
        ptr_load = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_req(VEC[i], PTR_A);
        end

        // R12: a second load replaces the pointer
        @(negedge clk);
        ptr_load = 1'b1;
        ptr_load_val = 64'h0000_0000_0000_1000;
        @(negedge clk);
        ptr_load = 1'b0;
        run_req(VEC[18], 64'h0000_0000_0000_1000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule